// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing controller of a small byte-wide serial memory that sits as a slave on a two-wire bus. The two bus lines are brought into the system clock domain, and the block detects start and stop conditions. It takes in a device-select byte and, for writes, a byte address. It answers each byte with an acknowledge, or with no acknowledge, through an open-drain pull-down enable. A master can write single bytes or a burst that stays inside an aligned page. It can read at the current pointer, load the pointer with a write-mode select followed by an address and then read, or stream through the whole array by acknowledging each byte it receives.

Written bytes go into a synchronous RAM of `DEPTH` bytes as they arrive. A stop that closes a write starts an internal busy window of `WR_CYCLES` system clocks. While that window is open the device does not acknowledge its own select byte, so the master can poll until the write has finished. Several devices can share one bus, each identified by its three strap inputs.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start condition, and the block then takes the next 8 bits as a select byte. A rising SDA while SCL is high is a stop condition, and the block returns to idle. After reset the SDA pull-down is off.
- R2: A start condition at any point aborts the transfer in progress. A partly received data byte is not stored, and the block waits for a new select byte.
- R3: A select byte whose bits [7:4] are 1010 and whose bits [3:1] equal `chip_sel_i` is acknowledged by pulling SDA low in the ninth clock. Bit 0 chooses the direction: 1 is read, 0 is write.
- R4: If the select byte does not match, SDA stays released, and every later byte is ignored (not acknowledged) until the next start.
- R5: In a write, the byte after the select byte is acknowledged and loads the address pointer. Only its low log2(DEPTH) bits are used, so with DEPTH=128 bit 7 is ignored.
- R6: Each data byte of a write is acknowledged and stored at the pointer. The pointer then advances only in its low log2(PAGE) bits, so a burst wraps inside its aligned page.
- R7: A read with no address phase returns the byte after the last one accessed. After the top location it returns location 0.
- R8: A write-mode select and an address byte, followed by a repeated start and a read-mode select, return the byte at the newly loaded address.
- R9: While reading, each master acknowledge makes the block send the next byte, wrapping from DEPTH-1 to 0. A master no-acknowledge ends the read.
- R10: After a stop that closes a write, the select byte is not acknowledged for WR_CYCLES clocks. After that it is acknowledged again.
- R11: The pull-down changes only after an SCL falling edge and never while SCL is high. It is released at the end of every ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| chip_sel_i | input | 3 | Strapped device number; tie unused bits to 0 |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Two functions can fall in the same system-clock cycle: a detected start condition, and the bit shifting or acknowledge decision that an SCL edge triggers. The start has priority. The bench provokes this case by breaking off a select byte after four bits and a data byte after five bits with a repeated start. It then judges the result at the pins: the fresh select must be acknowledged, and a read of the old address must return the earlier contents. A second case is the end of the busy window colliding with an acknowledge poll. The bench polls just after the stop and again after the window has closed, and expects no acknowledge and then an acknowledge.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } twm_state_e;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic              scl_q, sda_q;
  logic              scl_s, sda_s;

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= scl_i;
          sda_p <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[STAGES-2:0], scl_i};
          sda_p <= {sda_p[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // R1: data line edges while the clock line stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twm_ram.sv
module twm_ram #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/twm_busy_timer.sv
module twm_busy_timer #(
  parameter int CYCLES = 5000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic commit_i,
  output logic busy_o
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)              left_q <= '0;
    else if (commit_i)    left_q <= CW'(CYCLES);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != 0);

  // R10
  busy_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> busy_o);

  // R10
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !commit_i) |=> !busy_o);
endmodule

// File: rtl/twm_bus_fsm.sv
module twm_bus_fsm
  import twm_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PAGE  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [2:0]    chip_sel_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          ram_we_o,
  output logic [7:0]    ram_wdata_o,
  output logic          commit_o,
  output logic          sda_pull_o
);
  twm_state_e    state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    rx_q, tx_q;
  logic [AW-1:0] ptr_q, page_next;
  logic          is_read_q, wrote_q, mack_q;
  logic          match, load_now;
  logic [PW-1:0] low_next;

  // R3, R10: device code, strap match, and not in a write cycle
  assign match = (rx_q[7:4] == DEV_CODE) && (rx_q[3:1] == chip_sel_i) && !busy_i;

  // R6: advance inside the aligned page only
  always_comb begin
    low_next  = ptr_q[PW-1:0] + 1'b1;
    page_next = ptr_q;
    page_next[PW-1:0] = low_next;
  end

  assign load_now = scl_fall_i && !start_i && !stop_i &&
                    ((state_q == S_DACK && is_read_q) || (state_q == S_RACK && mack_q));

  always_ff @(posedge clk) begin
    ram_we_o <= 1'b0;
    commit_o <= 1'b0;
    if (rst) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      is_read_q   <= 1'b0;
      wrote_q     <= 1'b0;
      mack_q      <= 1'b0;
      sda_pull_o  <= 1'b0;
      ram_wdata_o <= '0;
    end else if (start_i) begin
      // R2: abort anything, expect a select byte
      state_q    <= S_DEV;
      cnt_q      <= '0;
      sda_pull_o <= 1'b0;
      wrote_q    <= 1'b0;
    end else if (stop_i) begin
      state_q    <= S_IDLE;
      sda_pull_o <= 1'b0;
      commit_o   <= wrote_q;
      wrote_q    <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        rx_q   <= {rx_q[6:0], sda_s_i};
        mack_q <= ~sda_s_i;
        if (cnt_q != 4'd8) cnt_q <= cnt_q + 1'b1;
      end
      if (load_now) begin
        // R7, R9: send byte at pointer, full-array wrap
        sda_pull_o <= ~rd_data_i[7];
        tx_q       <= {rd_data_i[6:0], 1'b0};
        ptr_q      <= ptr_q + 1'b1;
        cnt_q      <= '0;
        state_q    <= S_RDAT;
      end else if (scl_fall_i) begin
        case (state_q)
          S_DEV: if (cnt_q == 4'd8) begin
            if (match) begin
              sda_pull_o <= 1'b1;
              is_read_q  <= rx_q[0];
              state_q    <= S_DACK;
            end else begin
              state_q <= S_IDLE; // R4
            end
          end
          S_DACK: begin
            sda_pull_o <= 1'b0;
            cnt_q      <= '0;
            state_q    <= S_ADDR;
          end
          S_ADDR: if (cnt_q == 4'd8) begin
            ptr_q      <= rx_q[AW-1:0]; // R5
            sda_pull_o <= 1'b1;
            state_q    <= S_AACK;
          end
          S_AACK: begin
            sda_pull_o <= 1'b0;
            cnt_q      <= '0;
            state_q    <= S_WDAT;
          end
          S_WDAT: if (cnt_q == 4'd8) begin
            ram_we_o    <= 1'b1;
            ram_wdata_o <= rx_q;
            wrote_q     <= 1'b1;
            sda_pull_o  <= 1'b1;
            state_q     <= S_WACK;
          end
          S_WACK: begin
            sda_pull_o <= 1'b0;
            cnt_q      <= '0;
            ptr_q      <= page_next;
            state_q    <= S_WDAT;
          end
          S_RDAT: begin
            if (cnt_q == 4'd8) begin
              sda_pull_o <= 1'b0; // R11
              state_q    <= S_RACK;
            end else begin
              sda_pull_o <= ~tx_q[7];
              tx_q       <= {tx_q[6:0], 1'b0};
            end
          end
          S_RACK: state_q <= S_IDLE; // R9: master did not acknowledge
          default: ;
        endcase
      end
    end
  end

  assign ptr_o = ptr_q;

  // R11
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> $past(scl_fall_i));

  // R10
  no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DACK) |-> !busy_i);

  // R2
  start_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (state_q == S_DEV) && !sda_pull_o);

  // R9
  read_step_chk: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (ptr_q - $past(ptr_q)) == AW'(1));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int DEPTH       = 256,
  parameter int PAGE        = 8,
  parameter int WR_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel_i,
  output logic       sda_pull_o
);
  localparam int AW = $clog2(DEPTH);

  logic          sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic          busy, commit, ram_we;
  logic [AW-1:0] ptr;
  logic [7:0]    ram_wdata, ram_rdata;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twm_bus_fsm #(.DEPTH(DEPTH), .PAGE(PAGE)) u_fsm (
    .clk(clk), .rst(rst), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_c), .stop_i(stop_c),
    .chip_sel_i(chip_sel_i), .busy_i(busy), .rd_data_i(ram_rdata),
    .ptr_o(ptr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .commit_o(commit), .sda_pull_o(sda_pull_o)
  );

  twm_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .commit_i(commit), .busy_o(busy)
  );

  twm_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we_i(ram_we), .addr_i(ptr), .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );
endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q   = 8;
  localparam int WRC = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pull_a, pull_b, sda_line;
  int   checks = 0, errors = 0, viol = 0;
  logic scl_prev, pa_prev, pb_prev;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~pull_a & ~pull_b;

  serial_mem_slave #(.DEPTH(256), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .chip_sel_i(3'b000), .sda_pull_o(pull_a));

  serial_mem_slave #(.DEPTH(128), .WR_CYCLES(WRC)) dut_small_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .chip_sel_i(3'b001), .sda_pull_o(pull_b));

  // R11 monitor: pull-down must not move while the clock line is high
  always @(posedge clk) begin
    if (!rst && scl_m && scl_prev && (pull_a != pa_prev || pull_b != pb_prev))
      viol <= viol + 1;
    scl_prev <= scl_m;
    pa_prev  <= pull_a;
    pb_prev  <= pull_b;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(Q);
      scl_m = 1'b1;   tick(2*Q);
      scl_m = 1'b0;   tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = !sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      d = {d[6:0], sda_line}; tick(Q);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] sel, input logic [7:0] addr);
    bit a;
    bus_start();
    send_byte(sel, a);  chk(a, "R3", "select ack before address", a, 1);
    send_byte(addr, a); chk(a, "R5", "address ack", a, 1);
  endtask

  task automatic t_reset();
    chk(!pull_a && !pull_b, "R1", "pull-down off after reset", pull_a, 0);
  endtask

  task automatic t_select();
    bit a;
    bus_start(); send_byte(8'hA0, a); bus_stop();
    chk(a, "R3", "matching write select acked", a, 1);
    bus_start(); send_byte(8'hA6, a);
    chk(!a, "R4", "wrong strap not acked", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R4", "following byte ignored", a, 0);
    bus_stop();
    bus_start(); send_byte(8'hB0, a); bus_stop();
    chk(!a, "R3", "wrong device code not acked", a, 0);
  endtask

  task automatic t_write_poll();
    bit a;
    set_addr(8'hA0, 8'h10);
    send_byte(8'hA5, a); chk(a, "R6", "data byte 0 ack", a, 1);
    send_byte(8'h5A, a); chk(a, "R6", "data byte 1 ack", a, 1);
    bus_stop();
    bus_start(); send_byte(8'hA0, a); bus_stop();
    chk(!a, "R10", "select not acked while busy", a, 0);
    tick(WRC + 50);
    bus_start(); send_byte(8'hA0, a); bus_stop();
    chk(a, "R10", "select acked after write cycle", a, 1);
  endtask

  task automatic t_random_current();
    bit a; logic [7:0] d;
    set_addr(8'hA0, 8'h10);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'hA5, "R8", "random read data", d, 8'hA5);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h5A, "R7", "current address read", d, 8'h5A);
  endtask

  task automatic t_page();
    bit a; logic [7:0] d;
    set_addr(8'hA0, 8'h1E);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    bus_stop(); tick(WRC + 50);
    set_addr(8'hA0, 8'h18);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h33, "R6", "burst wrapped to page start", d, 8'h33);
    set_addr(8'hA0, 8'h1E);
    bus_start(); send_byte(8'hA1, a);
    recv_byte(1'b1, d); chk(d == 8'h11, "R9", "sequential byte 0", d, 8'h11);
    recv_byte(1'b0, d); chk(d == 8'h22, "R9", "sequential byte 1", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_wrap();
    bit a; logic [7:0] d;
    set_addr(8'hA0, 8'hFE);
    send_byte(8'h77, a); send_byte(8'hC3, a); bus_stop(); tick(WRC + 50);
    set_addr(8'hA0, 8'h00);
    send_byte(8'h3C, a); bus_stop(); tick(WRC + 50);
    set_addr(8'hA0, 8'hFE);
    bus_start(); send_byte(8'hA1, a);
    recv_byte(1'b1, d); chk(d == 8'h77, "R9", "seq at FE", d, 8'h77);
    recv_byte(1'b1, d); chk(d == 8'hC3, "R9", "seq at FF", d, 8'hC3);
    recv_byte(1'b0, d); chk(d == 8'h3C, "R9", "seq wrap to 00", d, 8'h3C);
    bus_stop();
    set_addr(8'hA0, 8'hFF);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); bus_stop();
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h3C, "R7", "current read wraps top to 0", d, 8'h3C);
  endtask

  task automatic t_abort();
    bit a; logic [7:0] d;
    bus_start(); send_bits(8'hA0, 4);
    bus_start(); send_byte(8'hA0, a);
    chk(a, "R2", "select after aborted select acked", a, 1);
    send_byte(8'h10, a);
    send_bits(8'h00, 5);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'hA5, "R2", "aborted data byte not stored", d, 8'hA5);
  endtask

  task automatic t_small();
    bit a; logic [7:0] d;
    bus_start(); send_byte(8'hA2, a);
    chk(a, "R3", "second strap acked", a, 1);
    send_byte(8'h85, a); send_byte(8'h9E, a); bus_stop(); tick(WRC + 50);
    set_addr(8'hA2, 8'h05);
    bus_start(); send_byte(8'hA3, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h9E, "R5", "address MSB ignored at 128 bytes", d, 8'h9E);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_select();
    t_write_poll();
    t_random_current();
    t_page();
    t_wrap();
    t_abort();
    t_small();
    chk(viol == 0, "R11", "pull-down changed while clock high", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run hung actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule